// File: doc/BRIEF.md
# Load-Adaptive Frequency-Hopping Oscillator

This block sets the switching period of a flyback PWM controller. Each switching cycle starts with a one-clock `cycle_start_o` pulse. The period length that applies to that cycle, counted in clock cycles, is driven on `period_o` so a duty limiter can scale against it. The load indicator is an unsigned code taken from the digitised voltage-loop error signal.

The code selects one of three regions:

- **Fixed region (heavy load).** The oscillator runs at its nominal period. A slow triangular dither is added to the period to spread the emission spectrum.
- **Fold-back region.** Below an upper code threshold, the period is interpolated linearly from the nominal value up to a floor period, with no dither.
- **Floor region.** Below a lower threshold, the period is held at the floor and a deep-standby flag is raised.

The period and the flag are captured only when a new cycle begins, so a change of load never shortens or stretches the cycle in progress.

The default parameters assume a 10 MHz clock. With that clock they give a nominal 42 kHz, a dither of about ±2.6 kHz, a dither cycle of about 3 ms and a floor of 550 Hz. Deasserting the enable stops the pulses, clears the period counter and returns the dither to its starting phase.

Top module: `load_hop_osc`

## Requirements
- R1: After reset `cycle_start_o` and `deep_standby_o` are 0 and `period_o` equals NOM_PERIOD. While `en_i` is 0, no `cycle_start_o` pulse occurs.
- R2: Consecutive `cycle_start_o` pulses are exactly as many clocks apart as the `period_o` value shown with the first of the two.
- R3: When the code sampled at a cycle start is at least HI_CODE, `period_o` equals NOM_PERIOD plus a dither offset and `deep_standby_o` is 0. The offset behaves as follows:
  - It is 0 at the first start after enable.
  - It moves by one every DITH_DIV fixed-region cycles: upward first, reversing on reaching +DITH_AMP and on reaching -DITH_AMP.
  - It stays within ±DITH_AMP and reaches both bounds.
- R4: When the sampled code c satisfies LO_CODE <= c < HI_CODE, `period_o` equals FLOOR_PERIOD - floor((FLOOR_PERIOD-NOM_PERIOD)*(c-LO_CODE)/(HI_CODE-LO_CODE)), with no dither, and `deep_standby_o` is 0.
- R5: When the sampled code is below LO_CODE, `period_o` equals FLOOR_PERIOD and `deep_standby_o` is 1.
- R6: `period_o` and `deep_standby_o` change only together with a `cycle_start_o` pulse. A code change in the middle of a period affects only the next period.
- R7: `cycle_start_o` is high for one clock. The first pulse comes on the first clock edge at which `en_i` is seen high. After re-enable, the dither offset starts again from 0.
- R8: During fold-back and floor cycles the dither phase is held. It resumes from where it stopped when the fixed region returns.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Synchronous run enable |
| load_code_i | input | CODE_W | Load indicator code |
| cycle_start_o | output | 1 | One-clock pulse at the start of each switching period |
| period_o | output | CNT_W | Length of the current period in clocks |
| deep_standby_o | output | 1 | High while the current period is the floor-region period |

## Verification
The load code is swept over every value of an 8-bit code, with a small period configuration. This places each code in the fixed, fold-back or floor region and checks the exact interpolated period and the standby flag at each step. The thresholds LO_CODE and HI_CODE and their neighbours separate the three regions. A long heavy-load run walks the dither through several full triangles, and the bench checks that both amplitude bounds are reached. Alternating heavy-load and fold-back runs check that the dither phase is held and then resumed. A code change in the middle of a period separates latching at the cycle boundary from immediate use. Disable and re-enable check the idle output and the restart of the dither from zero.

// File: rtl/lho_pkg.sv
package lho_pkg;
    typedef enum logic [1:0] {
        RGN_FIXED = 2'd0,
        RGN_FOLD  = 2'd1,
        RGN_FLOOR = 2'd2
    } region_e;
endpackage

// File: rtl/lho_dither.sv
module lho_dither #(
    parameter int DITH_AMP = 15,
    parameter int DITH_DIV = 2,
    parameter int OFS_W    = 6
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic                    clr_i,
    input  logic                    step_i,
    output logic signed [OFS_W-1:0] ofs_o
);
    localparam int DIV_W = (DITH_DIV > 1) ? $clog2(DITH_DIV) : 1;
    localparam logic signed [OFS_W-1:0] TOP_M1 = OFS_W'(DITH_AMP - 1);
    localparam logic signed [OFS_W-1:0] BOT_P1 = OFS_W'(1 - DITH_AMP);
    localparam logic signed [OFS_W-1:0] ONE    = OFS_W'(1);
    localparam logic [DIV_W-1:0]        DIV_LAST = DIV_W'(DITH_DIV - 1);

    typedef struct packed {
        logic signed [OFS_W-1:0] ofs;
        logic                    down;
        logic [DIV_W-1:0]        div;
    } dith_t;

    dith_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d = '0;
        end else if (step_i) begin
            if (st_q.div == DIV_LAST) begin
                st_d.div = '0;
                if (!st_q.down) begin
                    st_d.ofs = st_q.ofs + ONE;
                    if (st_q.ofs == TOP_M1) st_d.down = 1'b1;
                end else begin
                    st_d.ofs = st_q.ofs - ONE;
                    if (st_q.ofs == BOT_P1) st_d.down = 1'b0;
                end
            end else begin
                st_d.div = st_q.div + DIV_W'(1);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign ofs_o = st_q.ofs;

    AST_DITHER_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.ofs <= OFS_W'(DITH_AMP)) && (st_q.ofs >= -OFS_W'(DITH_AMP))); // R3
    AST_DITHER_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!step_i && !clr_i) |=> $stable(st_q.ofs)); // R8
endmodule

// File: rtl/lho_load_map.sv
module lho_load_map
    import lho_pkg::*;
#(
    parameter int CODE_W       = 8,
    parameter int CNT_W        = 16,
    parameter int OFS_W        = 6,
    parameter int NOM_PERIOD   = 238,
    parameter int FLOOR_PERIOD = 18182,
    parameter int HI_CODE      = 179,
    parameter int LO_CODE      = 51
) (
    input  logic [CODE_W-1:0]       code_i,
    input  logic signed [OFS_W-1:0] ofs_i,
    output logic [CNT_W-1:0]        per_o,
    output region_e                 rgn_o
);
    localparam int PROD_W = CNT_W + CODE_W;
    localparam logic [CNT_W-1:0]  NOM_V   = CNT_W'(NOM_PERIOD);
    localparam logic [CNT_W-1:0]  FLOOR_V = CNT_W'(FLOOR_PERIOD);
    localparam logic [PROD_W-1:0] DELTA_V = PROD_W'(FLOOR_PERIOD - NOM_PERIOD);
    localparam logic [PROD_W-1:0] SPAN_V  = PROD_W'(HI_CODE - LO_CODE);
    localparam logic [CODE_W-1:0] HI_V    = CODE_W'(HI_CODE);
    localparam logic [CODE_W-1:0] LO_V    = CODE_W'(LO_CODE);

    logic [CODE_W-1:0] diff;
    logic [PROD_W-1:0] prod;
    logic [CNT_W-1:0]  ofs_ext;

    always_comb begin
        diff    = code_i - LO_V;
        prod    = DELTA_V * PROD_W'(diff);
        ofs_ext = CNT_W'(ofs_i);
        if (code_i >= HI_V) begin
            rgn_o = RGN_FIXED;
            per_o = NOM_V + ofs_ext;
        end else if (code_i >= LO_V) begin
            rgn_o = RGN_FOLD;
            per_o = FLOOR_V - CNT_W'(prod / SPAN_V);
        end else begin
            rgn_o = RGN_FLOOR;
            per_o = FLOOR_V;
        end
    end

    initial begin
        assert (HI_CODE > LO_CODE && FLOOR_PERIOD > NOM_PERIOD);
    end
endmodule

// File: rtl/lho_period_ctr.sv
module lho_period_ctr #(
    parameter int CNT_W   = 16,
    parameter int RST_PER = 238
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic [CNT_W-1:0] tgt_per_i,
    input  logic             tgt_sb_i,
    output logic             take_o,
    output logic             start_o,
    output logic [CNT_W-1:0] per_o,
    output logic             sb_o
);
    typedef struct packed {
        logic             run;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] per;
        logic             sb;
        logic             start;
    } ctr_t;

    ctr_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.start = 1'b0;
        take_o     = en_i && (!st_q.run || (st_q.cnt == st_q.per - CNT_W'(1)));
        if (!en_i) begin
            st_d.run = 1'b0;
            st_d.cnt = '0;
        end else if (take_o) begin
            st_d.run   = 1'b1;
            st_d.cnt   = '0;
            st_d.per   = tgt_per_i;
            st_d.sb    = tgt_sb_i;
            st_d.start = 1'b1;
        end else begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q     <= '0;
            st_q.per <= CNT_W'(RST_PER);
        end else begin
            st_q <= st_d;
        end
    end

    assign start_o = st_q.start;
    assign per_o   = st_q.per;
    assign sb_o    = st_q.sb;

    AST_START_ONE_CLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.start |=> !st_q.start); // R7
    AST_NO_START_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> !st_q.start); // R1
    AST_PERIOD_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !st_q.start |-> ($stable(st_q.per) && $stable(st_q.sb))); // R6
    AST_CNT_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.run |-> (st_q.cnt < st_q.per)); // R2
endmodule

// File: rtl/load_hop_osc.sv
module load_hop_osc
    import lho_pkg::*;
#(
    parameter int CODE_W       = 8,
    parameter int CNT_W        = 16,
    parameter int NOM_PERIOD   = 238,
    parameter int FLOOR_PERIOD = 18182,
    parameter int DITH_AMP     = 15,
    parameter int DITH_DIV     = 2,
    parameter int HI_CODE      = 179,
    parameter int LO_CODE      = 51
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              en_i,
    input  logic [CODE_W-1:0] load_code_i,
    output logic              cycle_start_o,
    output logic [CNT_W-1:0]  period_o,
    output logic              deep_standby_o
);
    localparam int OFS_W = $clog2(DITH_AMP + 1) + 1;

    logic signed [OFS_W-1:0] ofs;
    logic [CNT_W-1:0]        tgt_per;
    region_e                 rgn;
    logic                    take;

    lho_dither #(
        .DITH_AMP (DITH_AMP),
        .DITH_DIV (DITH_DIV),
        .OFS_W    (OFS_W)
    ) u_dither (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (!en_i),
        .step_i (take && (rgn == RGN_FIXED)),
        .ofs_o  (ofs)
    );

    lho_load_map #(
        .CODE_W       (CODE_W),
        .CNT_W        (CNT_W),
        .OFS_W        (OFS_W),
        .NOM_PERIOD   (NOM_PERIOD),
        .FLOOR_PERIOD (FLOOR_PERIOD),
        .HI_CODE      (HI_CODE),
        .LO_CODE      (LO_CODE)
    ) u_map (
        .code_i (load_code_i),
        .ofs_i  (ofs),
        .per_o  (tgt_per),
        .rgn_o  (rgn)
    );

    lho_period_ctr #(
        .CNT_W   (CNT_W),
        .RST_PER (NOM_PERIOD)
    ) u_ctr (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .en_i      (en_i),
        .tgt_per_i (tgt_per),
        .tgt_sb_i  (rgn == RGN_FLOOR),
        .take_o    (take),
        .start_o   (cycle_start_o),
        .per_o     (period_o),
        .sb_o      (deep_standby_o)
    );

    AST_STANDBY_FLOOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        deep_standby_o |-> (period_o == CNT_W'(FLOOR_PERIOD))); // R5
endmodule

// File: tb/load_hop_osc_tb.sv
`timescale 1ns/1ps
module load_hop_osc_tb_top;
    localparam int CODE_W = 8;
    localparam int CNT_W  = 8;
    localparam int NOM    = 20;
    localparam int FLOOR  = 100;
    localparam int AMP    = 3;
    localparam int DIV    = 2;
    localparam int HI     = 12;
    localparam int LO     = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0;
    logic [CODE_W-1:0] code = '0;
    logic start;
    logic [CNT_W-1:0] per;
    logic sb;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    load_hop_osc #(
        .CODE_W(CODE_W), .CNT_W(CNT_W), .NOM_PERIOD(NOM), .FLOOR_PERIOD(FLOOR),
        .DITH_AMP(AMP), .DITH_DIV(DIV), .HI_CODE(HI), .LO_CODE(LO)
    ) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .en_i(en), .load_code_i(code),
        .cycle_start_o(start), .period_o(per), .deep_standby_o(sb)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    // bench model of the dither phase
    int m_ofs = 0;
    bit m_down = 1'b0;
    int m_div = 0;
    bit have_prev = 1'b0;
    int prev_per = 0;
    int prev_sb = 0;
    int gap = 0;
    int min_fixed = 1000;
    int max_fixed = -1;

    always @(negedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_ofs = 0; m_down = 1'b0; m_div = 0; have_prev = 1'b0;
        end else if (!en) begin
            m_ofs = 0; m_down = 1'b0; m_div = 0; have_prev = 1'b0;
            chk(start == 1'b0, "R1 no start while disabled", int'(start), 0);
        end else if (start) begin
            int c;
            int ep;
            int es;
            c = int'(code);
            if (have_prev) chk(gap == prev_per, "R2 start spacing", gap, prev_per);
            if (c >= HI) begin
                ep = NOM + m_ofs; es = 0;
                chk(int'(per) == ep, "R3 fixed period with dither", int'(per), ep);
                if (int'(per) < min_fixed) min_fixed = int'(per);
                if (int'(per) > max_fixed) max_fixed = int'(per);
                m_div++;
                if (m_div == DIV) begin
                    m_div = 0;
                    if (!m_down) begin m_ofs++; if (m_ofs == AMP) m_down = 1'b1; end
                    else begin m_ofs--; if (m_ofs == -AMP) m_down = 1'b0; end
                end
            end else if (c >= LO) begin
                ep = FLOOR - ((FLOOR - NOM) * (c - LO)) / (HI - LO); es = 0;
                chk(int'(per) == ep, "R4 fold-back period", int'(per), ep);
            end else begin
                ep = FLOOR; es = 1;
                chk(int'(per) == ep, "R5 floor period", int'(per), ep);
            end
            chk(int'(sb) == es, "R5 standby flag", int'(sb), es);
            have_prev = 1'b1; prev_per = int'(per); prev_sb = int'(sb); gap = 1;
        end else if (have_prev) begin
            gap++;
            chk(int'(per) == prev_per && int'(sb) == prev_sb, "R6 period held mid-cycle",
                int'(per), prev_per);
        end
    end

    task automatic wait_start();
        int n;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!start && n < 400);
        if (!start) chk(1'b0, "R2 start missing", 0, 1);
        #1;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #(5 * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(start == 1'b0, "R1 reset start", int'(start), 0);
        chk(sb == 1'b0, "R1 reset standby", int'(sb), 0);
        chk(int'(per) == NOM, "R1 reset period", int'(per), NOM);
        #1 rst_n = 1'b1;
        repeat (30) @(negedge clk);
        #1;
        // enable at heavy load: first start on the first edge that sees en
        code = 8'd255;
        en = 1'b1;
        @(negedge clk);
        chk(start == 1'b1, "R7 first start after enable", int'(start), 1);
        chk(int'(per) == NOM, "R7 dither starts at zero", int'(per), NOM);
        @(negedge clk);
        chk(start == 1'b0, "R7 start one clock wide", int'(start), 0);
        for (int i = 0; i < 60; i++) wait_start();
        chk(min_fixed == NOM - AMP, "R3 lower dither bound", min_fixed, NOM - AMP);
        chk(max_fixed == NOM + AMP, "R3 upper dither bound", max_fixed, NOM + AMP);
        // dither hold across fold-back (R8): model keeps the phase
        for (int k = 0; k < 3; k++) begin
            code = 8'd200;
            for (int i = 0; i < 5; i++) wait_start();
            code = 8'd8;
            for (int i = 0; i < 3; i++) wait_start();
        end
        // full sweep of codes, changed right after a start
        for (int c = 0; c < 256; c++) begin
            wait_start();
            code = CODE_W'(c);
            wait_start();
            wait_start();
        end
        // mid-period change (R6): takes effect only at the next start
        code = 8'd255;
        wait_start();
        wait_start();
        repeat (5) @(negedge clk);
        #1 code = 8'd0;
        wait_start();
        chk(sb == 1'b1, "R6 new code used at next start", int'(sb), 1);
        // disable, then re-enable: counter and dither restart (R7)
        code = 8'd255;
        wait_start();
        wait_start();
        repeat (3) @(negedge clk);
        #1 en = 1'b0;
        repeat (12) @(negedge clk);
        #1 en = 1'b1;
        @(negedge clk);
        chk(start == 1'b1, "R7 restart after re-enable", int'(start), 1);
        chk(int'(per) == NOM, "R7 dither reset on re-enable", int'(per), NOM);
        for (int i = 0; i < 4; i++) wait_start();
        done = 1'b1;
        finish_run();
    end
endmodule